// File: doc/BRIEF.md
# Time-Trigger Timer Status Unit

This block keeps the time base for a time-triggered schedule. A 16-bit timer advances by one on every cycle in which the single-cycle `tick` input is high. Three compare registers watch the timer. Compare register 0 can also act as the period limit: when enabled, it restarts the timer from zero. A 3-bit cycle counter counts the timer periods up to a programmable maximum and then starts again from zero.

Five sticky status flags record the timer events. They are timer overrun, one compare match for each of the three compare registers, and cycle counter overflow. Software cannot set a flag. It clears a flag by writing 1 to the matching bit of the flag register. Each flag drives an interrupt request line through its own enable bit.

Software uses a plain synchronous write port and a combinational read port, both with a 3-bit address.

Top module: `tt_timer_status`

## Requirements
- R1: After reset, every readable location reads 0 and every `irq` line is low.
- R2: The timer (read at address 6) increments by one on each clock edge where `tick` is 1 and holds otherwise. A tick taken at 16'hFFFF gives 0 and sets flag bit 0 (overrun).
- R3: Flag bit n+1 (n = 0, 1, 2) sets on the edge where the timer takes the value held in compare register n (addresses 1, 2 and 3). It never sets while that register holds 0.
- R4: Control bit 0 (address 0) enables restart. When it is 1 and compare register 0 is nonzero, a tick taken while the timer equals that register loads 0 into the timer. If that register holds 16'hFFFF, the overrun flag still sets.
- R5: Each return of the timer to 0, whether by wrap or by restart, is one cycle event. The cycle counter is read at address 7, and its maximum sits in control bits 3:1. A cycle event advances the counter by one. If the counter is already at the maximum, the event returns it to 0 and sets flag bit 4.
- R6: While the maximum is 0, the cycle counter stays at 0 and flag bit 4 reads 0. This holds from the clock edge after the maximum becomes 0.
- R7: Flags are read at address 4. A write there clears the flags whose data bits are 1 and leaves the others unchanged. No other write changes a flag.
- R8: If a flag's set condition and its write-1 clear fall in the same cycle, the flag ends up set.
- R9: `irq[i]` is high exactly when flag bit i is set and bit i of the enable register (address 5) is 1.
- R10: Addresses 0, 1 to 3 and 5 read back the last value written there, limited to the field widths (4 control bits, 16 compare bits, 5 enable bits). Writes to addresses 6 and 7 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Timer advance strobe, one cycle wide |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 16 | Read data for `rd_addr`, combinational |
| irq | output | 5 | Interrupt requests: bit 0 overrun, bits 1-3 compare 0-2, bit 4 cycle overflow |

## Verification
Two kinds of event can land on the same edge. The first is a flag being set while software writes 1 to clear that same flag. The bench provokes this by steering the timer to one below compare register 1 and then issuing the clear together with the tick that reaches the match; the flag must read 1 afterwards. The second is a restart by compare 0 that coincides with the 16'hFFFF wrap. With compare 0 at 16'hFFFF, the bench checks that the timer reads 0, that the overrun flag is set, and that the cycle counter advanced by one and not two. Random traffic then mixes ticks, clears and reconfiguration against a reference model that is written from the requirements.

// File: rtl/tts_pkg.sv
package tts_pkg;
    localparam int NCMP  = 3;
    localparam int NFLAG = NCMP + 2;
    localparam int AW    = 3;

    localparam logic [AW-1:0] ADR_CTRL = 3'd0;
    localparam logic [AW-1:0] ADR_CMP0 = 3'd1;
    localparam logic [AW-1:0] ADR_FLAG = 3'd4;
    localparam logic [AW-1:0] ADR_IEN  = 3'd5;
    localparam logic [AW-1:0] ADR_TMR  = 3'd6;
    localparam logic [AW-1:0] ADR_CYC  = 3'd7;

    localparam int FB_OVR = 0;
    localparam int FB_CYC = NFLAG - 1;
endpackage

// File: rtl/tts_timer.sv
module tts_timer
    import tts_pkg::*;
#(
    parameter int TW = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     tick,
    input  logic                     clr_en,
    input  logic [NCMP-1:0][TW-1:0]  cmp,
    output logic [TW-1:0]            timer,
    output logic                     wrap,
    output logic                     reload,
    output logic [NCMP-1:0]          hit
);
    typedef struct packed {
        logic [TW-1:0] cnt;
    } tmr_st_t;

    tmr_st_t st_d, st_q;
    logic [NCMP-1:0] armed;

    // next value of the timer; restart has priority over increment
    always_comb begin
        st_d   = st_q;
        wrap   = tick && (&st_q.cnt);
        reload = tick && clr_en && armed[0] && (st_q.cnt == cmp[0]);
        if (reload) begin
            st_d.cnt = '0;
        end else if (tick) begin
            st_d.cnt = st_q.cnt + TW'(1);
        end
    end

    // one comparator per compare register; a zero value disarms it
    for (genvar n = 0; n < NCMP; n++) begin : g_cmp
        assign armed[n] = |cmp[n];
        assign hit[n]   = tick && armed[n] && (st_d.cnt == cmp[n]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign timer = st_q.cnt;
endmodule

// File: rtl/tts_cycle.sv
module tts_cycle #(
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          evt,
    input  logic [CW-1:0] cmax,
    output logic [CW-1:0] count,
    output logic          ovf
);
    typedef struct packed {
        logic [CW-1:0] cnt;
    } cyc_st_t;

    cyc_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        ovf  = 1'b0;
        if (cmax == '0) begin
            st_d.cnt = '0;
        end else if (evt) begin
            if (st_q.cnt == cmax) begin
                st_d.cnt = '0;
                ovf      = 1'b1;
            end else if (st_q.cnt > cmax) begin
                // maximum lowered below the count: restart quietly
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + CW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count = st_q.cnt;
endmodule

// File: rtl/tts_flags.sv
module tts_flags #(
    parameter int NF = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NF-1:0] set,
    input  logic [NF-1:0] clr,
    input  logic [NF-1:0] hold_off,
    input  logic [NF-1:0] ien,
    output logic [NF-1:0] flags,
    output logic [NF-1:0] irq
);
    typedef struct packed {
        logic [NF-1:0] f;
    } flg_st_t;

    flg_st_t st_d, st_q;

    // set beats clear; a held-off flag is forced low
    always_comb begin
        st_d   = st_q;
        st_d.f = ((st_q.f & ~clr) | set) & ~hold_off;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flags = st_q.f;
    assign irq   = st_q.f & ien;
endmodule

// File: rtl/tt_timer_status.sv
module tt_timer_status
    import tts_pkg::*;
#(
    parameter int TW = 16,
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [TW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [TW-1:0] rd_data,
    output logic [NFLAG-1:0] irq
);
    localparam int CTLW = CW + 1;

    typedef struct packed {
        logic                    clr_en;
        logic [CW-1:0]           cmax;
        logic [NCMP-1:0][TW-1:0] cmp;
        logic [NFLAG-1:0]        ien;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    logic [TW-1:0]    timer_w;
    logic             wrap_w;
    logic             reload_w;
    logic [NCMP-1:0]  hit_w;
    logic [CW-1:0]    cyc_w;
    logic             cyc_ovf_w;
    logic [NFLAG-1:0] set_w;
    logic [NFLAG-1:0] clr_w;
    logic [NFLAG-1:0] hold_w;
    logic [NFLAG-1:0] flags_w;

    // configuration register writes
    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            if (wr_addr == ADR_CTRL) begin
                cfg_d.clr_en = wr_data[0];
                cfg_d.cmax   = wr_data[CW:1];
            end
            if (wr_addr == ADR_IEN) begin
                cfg_d.ien = wr_data[NFLAG-1:0];
            end
            for (int n = 0; n < NCMP; n++) begin
                if (wr_addr == AW'(int'(ADR_CMP0) + n)) begin
                    cfg_d.cmp[n] = wr_data;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    // flag event routing: bit 0 overrun, 1..NCMP compares, top bit cycle
    always_comb begin
        set_w          = {cyc_ovf_w, hit_w, wrap_w};
        clr_w          = (wr_en && wr_addr == ADR_FLAG) ? wr_data[NFLAG-1:0] : '0;
        hold_w         = '0;
        hold_w[FB_CYC] = (cfg_q.cmax == '0);
    end

    // read multiplexer
    always_comb begin
        rd_data = '0;
        case (rd_addr)
            ADR_CTRL: rd_data = TW'({cfg_q.cmax, cfg_q.clr_en});
            ADR_FLAG: rd_data = TW'(flags_w);
            ADR_IEN:  rd_data = TW'(cfg_q.ien);
            ADR_TMR:  rd_data = timer_w;
            ADR_CYC:  rd_data = TW'(cyc_w);
            default: begin
                for (int n = 0; n < NCMP; n++) begin
                    if (rd_addr == AW'(int'(ADR_CMP0) + n)) begin
                        rd_data = cfg_q.cmp[n];
                    end
                end
            end
        endcase
    end

    tts_timer #(.TW(TW)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .clr_en (cfg_q.clr_en),
        .cmp    (cfg_q.cmp),
        .timer  (timer_w),
        .wrap   (wrap_w),
        .reload (reload_w),
        .hit    (hit_w)
    );

    tts_cycle #(.CW(CW)) u_cycle (
        .clk   (clk),
        .rst_n (rst_n),
        .evt   (wrap_w | reload_w),
        .cmax  (cfg_q.cmax),
        .count (cyc_w),
        .ovf   (cyc_ovf_w)
    );

    tts_flags #(.NF(NFLAG)) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .set      (set_w),
        .clr      (clr_w),
        .hold_off (hold_w),
        .ien      (cfg_q.ien),
        .flags    (flags_w),
        .irq      (irq)
    );

    logic unused_ctlw;
    assign unused_ctlw = (CTLW > TW);
endmodule

// File: rtl/tts_chk.sv
module tts_chk
    import tts_pkg::*;
#(
    parameter int TW = 16,
    parameter int CW = 3
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    tick,
    input logic                    wr_en,
    input logic [AW-1:0]           wr_addr,
    input logic [TW-1:0]           wr_data,
    input logic [TW-1:0]           timer,
    input logic                    clr_en,
    input logic [CW-1:0]           cmax,
    input logic [NCMP-1:0][TW-1:0] cmp,
    input logic [CW-1:0]           cyc,
    input logic [NFLAG-1:0]        flags
);
    logic flag_wr;
    assign flag_wr = wr_en && (wr_addr == ADR_FLAG);

    a_r2_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        tick && (&timer) |=> flags[FB_OVR] && (timer == '0));

    a_r4_restart: assert property (@(posedge clk) disable iff (!rst_n)
        tick && clr_en && (cmp[0] != '0) && (timer == cmp[0]) |=> (timer == '0));

    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(timer));

    a_r6_cyc_off: assert property (@(posedge clk) disable iff (!rst_n)
        (cmax == '0) |=> (cyc == '0) && !flags[FB_CYC]);

    a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        tick && (&timer) && flag_wr && wr_data[FB_OVR] |=> flags[FB_OVR]);

    for (genvar n = 0; n < NCMP; n++) begin : g_zero
        a_r3_zero_cmp: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(flags[n + 1]) |-> ($past(cmp[n]) != '0));
    end

    for (genvar i = 0; i < NFLAG; i++) begin : g_sticky
        a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            flags[i] && !(flag_wr && wr_data[i]) && !(i == FB_CYC && cmax == '0)
            |=> flags[i]);
    end
endmodule

bind tt_timer_status tts_chk #(.TW(TW), .CW(CW)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .timer   (timer_w),
    .clr_en  (cfg_q.clr_en),
    .cmax    (cfg_q.cmax),
    .cmp     (cfg_q.cmp),
    .cyc     (cyc_w),
    .flags   (flags_w)
);

// File: tb/tt_timer_status_tb_top.sv
`timescale 1ns/100ps
module tt_timer_status_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        tick;
    logic        wr_en;
    logic [2:0]  wr_addr;
    logic [15:0] wr_data;
    logic [2:0]  rd_addr;
    logic [15:0] rd_data;
    logic [4:0]  irq;

    always #2.5 clk = ~clk;

    tt_timer_status dut_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
    );

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // reference state, kept from the requirements
    logic [15:0] m_timer;
    logic [2:0]  m_cyc;
    logic [4:0]  m_flags;
    logic [4:0]  m_en;
    logic        m_clr_en;
    logic [2:0]  m_cmax;
    logic [15:0] m_cmp [3];

    task automatic model_reset();
        m_timer = 0; m_cyc = 0; m_flags = 0; m_en = 0; m_clr_en = 0; m_cmax = 0;
        for (int n = 0; n < 3; n++) m_cmp[n] = 0;
    endtask

    task automatic model_step(input logic t, input logic we, input logic [2:0] a,
                              input logic [15:0] d);
        logic [15:0] nt;
        logic        rs, wr;
        logic [4:0]  st, wc;
        logic [2:0]  nc;
        rs = t && m_clr_en && (m_cmp[0] != 0) && (m_timer == m_cmp[0]);
        wr = t && (m_timer == 16'hFFFF);
        nt = rs ? 16'h0 : (t ? m_timer + 16'd1 : m_timer);
        st = 0;
        st[0] = wr;
        for (int n = 0; n < 3; n++) st[n + 1] = t && (m_cmp[n] != 0) && (nt == m_cmp[n]);
        nc = m_cyc;
        if (m_cmax == 0) nc = 0;
        else if (rs || wr) begin
            if (m_cyc == m_cmax) begin nc = 0; st[4] = 1'b1; end
            else if (m_cyc > m_cmax) nc = 0;
            else nc = m_cyc + 3'd1;
        end
        wc = (we && a == 3'd4) ? d[4:0] : 5'd0;
        m_flags = (m_flags & ~wc) | st;
        if (m_cmax == 0) m_flags[4] = 1'b0;
        m_timer = nt;
        m_cyc   = nc;
        if (we) begin
            case (a)
                3'd0: begin m_clr_en = d[0]; m_cmax = d[3:1]; end
                3'd1: m_cmp[0] = d;
                3'd2: m_cmp[1] = d;
                3'd3: m_cmp[2] = d;
                3'd5: m_en = d[4:0];
                default: ;
            endcase
        end
    endtask

    function automatic logic [15:0] model_read(input logic [2:0] ra);
        case (ra)
            3'd0: return {12'd0, m_cmax, m_clr_en};
            3'd1: return m_cmp[0];
            3'd2: return m_cmp[1];
            3'd3: return m_cmp[2];
            3'd4: return {11'd0, m_flags};
            3'd5: return {11'd0, m_en};
            3'd6: return m_timer;
            default: return {13'd0, m_cyc};
        endcase
    endfunction

    function automatic string tag_of(input logic [2:0] ra);
        case (ra)
            3'd4: return "R7";
            3'd6: return "R2";
            3'd7: return "R5";
            default: return "R10";
        endcase
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h (time %0t)", req, act, exp, $time);
        end
    endtask

    task automatic step(input logic t, input logic we, input logic [2:0] a,
                        input logic [15:0] d, input logic [2:0] ra);
        @(negedge clk);
        tick = t; wr_en = we; wr_addr = a; wr_data = d; rd_addr = ra;
        @(posedge clk);
        model_step(t, we, a, d);
        #1;
        chk(tag_of(ra), rd_data, model_read(ra));
        chk("R9", {11'd0, irq}, {11'd0, m_flags & m_en});
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            finish_run();
        end
    end

    initial begin
        logic [15:0] keep;
        void'($urandom(32'h5eed_0c1a));
        rst_n = 1'b0; tick = 0; wr_en = 0; wr_addr = 0; wr_data = 0; rd_addr = 0;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset state on every address and irq
        for (int a = 0; a < 8; a++) begin
            step(0, 0, 0, 0, 3'(a));
            chk("R1", rd_data, 16'h0);
            chk("R1", {11'd0, irq}, 16'h0);
        end

        // R2 wrap with all compares at zero (R3 must stay quiet)
        for (int i = 0; i < 65536; i++) step(1, 0, 0, 0, 3'(i));
        step(0, 0, 0, 0, 6);
        chk("R2", rd_data, 16'h0);
        step(0, 0, 0, 0, 4);
        chk("R2", rd_data & 16'h1, 16'h1);
        chk("R3", rd_data & 16'hE, 16'h0);
        chk("R6", rd_data & 16'h10, 16'h0);

        // configure: clear flags, enable irqs, cmp1=5, cmp0=10, restart on, max=2
        step(0, 1, 4, 16'h1F, 4);
        chk("R7", rd_data, 16'h0);
        step(0, 1, 5, 16'h1F, 5);
        step(0, 1, 2, 16'd5, 2);
        step(0, 1, 1, 16'd10, 1);
        step(0, 1, 0, 16'h0005, 0);
        chk("R10", rd_data, 16'h0005);

        // R8: clear of compare-1 flag on the very edge it sets
        while (m_timer != 16'd4) step(1, 0, 0, 0, 6);
        step(1, 1, 4, 16'h0004, 4);
        chk("R8", rd_data & 16'h4, 16'h4);
        chk("R9", {15'd0, irq[2]}, 16'h1);

        // R4: restart at compare 0
        while (m_timer != 16'd10) step(1, 0, 0, 0, 6);
        step(1, 0, 0, 0, 6);
        chk("R4", rd_data, 16'h0);

        // R5: counter at maximum returns to 0 and raises bit 4
        while (m_cyc != 3'd2) step(1, 0, 0, 0, 7);
        while (m_cyc == 3'd2) step(1, 0, 0, 0, 7);
        chk("R5", rd_data, 16'h0);
        step(0, 0, 0, 0, 4);
        chk("R5", rd_data & 16'h10, 16'h10);

        // R6: maximum written to zero forces bit 4 low and holds the counter
        step(0, 1, 0, 16'h0001, 0);
        step(0, 0, 0, 0, 4);
        chk("R6", rd_data & 16'h10, 16'h0);
        for (int i = 0; i < 30; i++) step(1, 0, 0, 0, 7);
        chk("R6", rd_data, 16'h0);

        // R7: writing zeros leaves flags; R10: timer not writable
        step(0, 0, 0, 0, 4);
        keep = rd_data;
        step(0, 1, 4, 16'h0, 4);
        chk("R7", rd_data, keep);
        step(0, 0, 0, 0, 6);
        keep = rd_data;
        step(0, 1, 6, 16'h1234, 6);
        chk("R10", rd_data, keep);
        step(0, 1, 7, 16'h0005, 7);
        chk("R10", rd_data, 16'h0);

        // R4 corner: compare 0 at FFFF with restart still sets overrun, one cycle event
        step(0, 1, 4, 16'h1F, 4);
        step(0, 1, 1, 16'hFFFF, 1);
        step(0, 1, 2, 16'h0, 2);
        step(0, 1, 0, 16'h0003, 0);
        while (m_timer != 16'hFFFF) step(1, 0, 0, 0, 3'(m_timer));
        step(1, 0, 0, 0, 6);
        chk("R4", rd_data, 16'h0);
        step(0, 0, 0, 0, 4);
        chk("R4", rd_data & 16'h1, 16'h1);
        step(0, 0, 0, 0, 7);
        chk("R5", rd_data, 16'h1);

        // random traffic with a short restart period
        step(0, 1, 1, 16'd23, 1);
        step(0, 1, 0, 16'h0007, 0);
        for (int i = 0; i < 4000; i++) begin
            logic        t, we;
            logic [2:0]  a;
            logic [15:0] d;
            t  = ($urandom % 4) != 0;
            we = ($urandom % 8) == 0;
            a  = 3'($urandom % 8);
            case (a)
                3'd0:    d = 16'($urandom % 16) | 16'h1;
                3'd1:    d = 16'($urandom % 40) + 16'd1;
                3'd2,
                3'd3:    d = 16'($urandom % 48);
                default: d = 16'($urandom % 32);
            endcase
            step(t, we, a, d, 3'($urandom % 8));
        end

        done = 1'b1;
        finish_run();
    end
endmodule